// File: doc/BRIEF.md
# DMA Channel Completion Status Unit

This block watches each channel of a multi-channel DMA engine and records how its operation ends. A start command (from a control register write) is screened against the channel's byte count and its size configuration. A bad start ends the operation at once as an abnormal completion, and no transfer takes place. A good start marks the channel busy.

While the channel is busy, three strobes from the datapath can end the operation:

- A normal-done strobe ends it normally.
- A source-side bus error strobe ends it abnormally and records where the fault came from.
- A destination-side bus error strobe does the same for the destination side.

Four sticky flags hold the outcome: normal end, abnormal end, source fault and destination fault. Each channel has one interrupt request. It is raised by the normal flag when that channel's normal enable is set, or by the abnormal flag when its abnormal enable is set. An explicit clear input wipes a channel's flags. A fresh start also wipes them before its checks run.

Top module: `dma_cmpl_status`

## Requirements
- R1: After reset every channel reads not busy, all four flags read 0, and every interrupt request reads 0.
- R2: A start with a nonzero count and a legal size pairing makes the channel busy one cycle later, with all four flags 0.
- R3: A done strobe on a busy channel, with no error strobe in the same cycle, sets the normal flag and clears busy, both visible one cycle later.
- R4: A source error strobe on a busy channel sets the abnormal flag and the source-fault flag, and clears busy in that same update. A destination error strobe does the same with the destination-fault flag. Both strobes together set both fault flags.
- R5: An error strobe arriving in the same cycle as a done strobe wins: the abnormal flag is set and the normal flag stays 0.
- R6: A start while the byte count is 0 sets the abnormal flag one cycle later, and the channel does not become busy.
- R7: Size codes are 0 = byte, 1 = 16-bit, 2 = 32-bit and 3 = reserved. A start with code 3 in either the port size or the unit size ends abnormally, as in R6.
- R8: With ALLOW_WIDE_UNIT = 0, a start whose unit code is larger than its port code ends abnormally. With ALLOW_WIDE_UNIT = 1, that pairing is legal and the channel becomes busy.
- R9: Done and error strobes on a channel that is not busy change neither its flags nor its busy state.
- R10: Flags hold their value until cleared. A clear (without start) zeros all four flags one cycle later and leaves busy unchanged.
- R11: A start zeros all flags left from an earlier operation before its own checks are applied.
- R12: Each interrupt request equals (normal flag AND normal enable) OR (abnormal flag AND abnormal enable) of its channel. It follows the enables in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | NUM_CH | Start command pulse per channel |
| clear_i | input | NUM_CH | Flag clear pulse per channel |
| byte_cnt_i | input | NUM_CH*CNT_W | Current byte count per channel |
| port_size_i | input | NUM_CH*2 | Device port size code per channel |
| unit_size_i | input | NUM_CH*2 | Transfer unit size code per channel |
| src_err_i | input | NUM_CH | Source-side bus error strobe |
| dst_err_i | input | NUM_CH | Destination-side bus error strobe |
| done_i | input | NUM_CH | Normal-done strobe |
| nrm_ie_i | input | NUM_CH | Normal completion interrupt enable |
| abn_ie_i | input | NUM_CH | Abnormal completion interrupt enable |
| busy_o | output | NUM_CH | Channel operation in progress |
| nrm_flag_o | output | NUM_CH | Sticky normal completion flag |
| abn_flag_o | output | NUM_CH | Sticky abnormal completion flag |
| src_flag_o | output | NUM_CH | Sticky source bus fault flag |
| dst_flag_o | output | NUM_CH | Sticky destination bus fault flag |
| irq_o | output | NUM_CH | Completion interrupt request per channel |

## Verification
The bench builds two copies with NUM_CH = 3 and CNT_W = 4, one with ALLOW_WIDE_UNIT = 0 and one with ALLOW_WIDE_UNIT = 1. Both copies are driven from the same inputs, so a single wide-unit start shows the prohibited outcome and the legal outcome side by side.

The 4-bit count makes a zero count common under random stimulus. Three channels let concurrent starts, strobes and clears on neighbouring channels show that each channel's state stays separate.

// File: rtl/dma_cs_pkg.sv
package dma_cs_pkg;

   localparam int SZ_W = 2;

   typedef enum logic [SZ_W-1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } xfer_size_e;

   typedef struct packed {
      logic nrm;
      logic abn;
      logic src;
      logic dst;
   } cmpl_flags_t;

endpackage

// File: rtl/dma_cs_cfg_chk.sv
module dma_cs_cfg_chk
   import dma_cs_pkg::*;
#(
   parameter int CNT_W           = 16,
   parameter bit ALLOW_WIDE_UNIT = 1'b0
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [SZ_W-1:0]  port_sz_i,
   input  logic [SZ_W-1:0]  unit_sz_i,
   output logic             cnt_zero_o,
   output logic             cfg_bad_o
);

   logic rsvd_code;
   logic width_bad;

   initial begin
      if (CNT_W < 1) $error("dma_cs_cfg_chk: CNT_W must be at least 1");
   end

   assign cnt_zero_o = (cnt_i == '0);
   assign rsvd_code  = (port_sz_i == SZ_RSVD) || (unit_sz_i == SZ_RSVD);

   generate
      if (ALLOW_WIDE_UNIT) begin : g_wide_ok
         assign width_bad = 1'b0;
      end else begin : g_wide_bad
         assign width_bad = (unit_sz_i > port_sz_i);
      end
   endgenerate

   assign cfg_bad_o = rsvd_code || width_bad;

endmodule

// File: rtl/dma_cs_chan.sv
module dma_cs_chan
   import dma_cs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        clear_i,
   input  logic        cnt_zero_i,
   input  logic        cfg_bad_i,
   input  logic        src_err_i,
   input  logic        dst_err_i,
   input  logic        done_i,
   output logic        busy_o,
   output cmpl_flags_t flags_o
);

   logic        busy_q;
   cmpl_flags_t flg_q;
   logic        any_err;

   assign any_err = src_err_i || dst_err_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         flg_q  <= '0;
      end else if (start_i) begin
         flg_q <= '0;
         if (cnt_zero_i || cfg_bad_i) begin
            flg_q.abn <= 1'b1;
            busy_q    <= 1'b0;
         end else begin
            busy_q <= 1'b1;
         end
      end else if (clear_i) begin
         flg_q <= '0;
      end else if (busy_q) begin
         if (any_err) begin
            flg_q.abn <= 1'b1;
            flg_q.src <= flg_q.src || src_err_i;
            flg_q.dst <= flg_q.dst || dst_err_i;
            busy_q    <= 1'b0;
         end else if (done_i) begin
            flg_q.nrm <= 1'b1;
            busy_q    <= 1'b0;
         end
      end
   end

   assign busy_o  = busy_q;
   assign flags_o = flg_q;

   a_r2_good_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !cnt_zero_i && !cfg_bad_i |=> busy_q && (flg_q == '0));

   a_r3_normal_end: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && done_i && !any_err && !start_i && !clear_i |=> flg_q.nrm && !busy_q);

   a_r4_src_fault: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && src_err_i && !start_i && !clear_i |=> flg_q.abn && flg_q.src && !busy_q);

   a_r4_dst_fault: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && dst_err_i && !start_i && !clear_i |=> flg_q.abn && flg_q.dst && !busy_q);

   a_r5_err_wins: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && any_err && done_i && !flg_q.nrm && !start_i && !clear_i |=> !flg_q.nrm);

   a_r6_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && cnt_zero_i |=> flg_q.abn && !busy_q);

   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q && !start_i && !clear_i |=> $stable(flg_q) && !busy_q);

   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i && !start_i |=> (flg_q == '0) && (busy_q == $past(busy_q)));

endmodule

// File: rtl/dma_cmpl_status.sv
module dma_cmpl_status
   import dma_cs_pkg::*;
#(
   parameter int NUM_CH          = 8,
   parameter int CNT_W           = 16,
   parameter bit ALLOW_WIDE_UNIT = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH-1:0]       start_i,
   input  logic [NUM_CH-1:0]       clear_i,
   input  logic [NUM_CH*CNT_W-1:0] byte_cnt_i,
   input  logic [NUM_CH*SZ_W-1:0]  port_size_i,
   input  logic [NUM_CH*SZ_W-1:0]  unit_size_i,
   input  logic [NUM_CH-1:0]       src_err_i,
   input  logic [NUM_CH-1:0]       dst_err_i,
   input  logic [NUM_CH-1:0]       done_i,
   input  logic [NUM_CH-1:0]       nrm_ie_i,
   input  logic [NUM_CH-1:0]       abn_ie_i,
   output logic [NUM_CH-1:0]       busy_o,
   output logic [NUM_CH-1:0]       nrm_flag_o,
   output logic [NUM_CH-1:0]       abn_flag_o,
   output logic [NUM_CH-1:0]       src_flag_o,
   output logic [NUM_CH-1:0]       dst_flag_o,
   output logic [NUM_CH-1:0]       irq_o
);

   initial begin
      if (NUM_CH < 1)  $error("dma_cmpl_status: NUM_CH must be at least 1");
      if (CNT_W < 1)   $error("dma_cmpl_status: CNT_W must be at least 1");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic        cnt_zero;
      logic        cfg_bad;
      cmpl_flags_t flg;

      dma_cs_cfg_chk #(
         .CNT_W           (CNT_W),
         .ALLOW_WIDE_UNIT (ALLOW_WIDE_UNIT)
      ) i_cfg (
         .cnt_i      (byte_cnt_i[c*CNT_W +: CNT_W]),
         .port_sz_i  (port_size_i[c*SZ_W +: SZ_W]),
         .unit_sz_i  (unit_size_i[c*SZ_W +: SZ_W]),
         .cnt_zero_o (cnt_zero),
         .cfg_bad_o  (cfg_bad)
      );

      dma_cs_chan i_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .start_i    (start_i[c]),
         .clear_i    (clear_i[c]),
         .cnt_zero_i (cnt_zero),
         .cfg_bad_i  (cfg_bad),
         .src_err_i  (src_err_i[c]),
         .dst_err_i  (dst_err_i[c]),
         .done_i     (done_i[c]),
         .busy_o     (busy_o[c]),
         .flags_o    (flg)
      );

      assign nrm_flag_o[c] = flg.nrm;
      assign abn_flag_o[c] = flg.abn;
      assign src_flag_o[c] = flg.src;
      assign dst_flag_o[c] = flg.dst;
      assign irq_o[c]      = (flg.nrm && nrm_ie_i[c]) || (flg.abn && abn_ie_i[c]);

      a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rst_n) |-> !busy_o[c] && !irq_o[c]);

      a_r4_fault_implies_abn: assert property (@(posedge clk) disable iff (!rst_n)
         (flg.src || flg.dst) |-> flg.abn);
   end

endmodule

// File: tb/test_dma_cmpl_status.sv
module test_dma_cmpl_status;

   localparam int NCH  = 3;
   localparam int CW   = 4;
   localparam int TCLK = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0]    start, clear, serr, derr, done, nie, aie;
   logic [NCH*CW-1:0] cnt;
   logic [NCH*2-1:0]  psz, usz;

   logic [NCH-1:0] busy [2];
   logic [NCH-1:0] nf   [2];
   logic [NCH-1:0] af   [2];
   logic [NCH-1:0] sf   [2];
   logic [NCH-1:0] df   [2];
   logic [NCH-1:0] irq  [2];

   bit mb [2][NCH];
   bit mn [2][NCH];
   bit ma [2][NCH];
   bit ms [2][NCH];
   bit md [2][NCH];

   int checks = 0;
   int errors = 0;
   string cur = "R1";

   always #(TCLK/2) clk = ~clk;

   dma_cmpl_status #(.NUM_CH(NCH), .CNT_W(CW), .ALLOW_WIDE_UNIT(1'b0)) i_dma_cmpl_status (
      .clk(clk), .rst_n(rst_n), .start_i(start), .clear_i(clear), .byte_cnt_i(cnt),
      .port_size_i(psz), .unit_size_i(usz), .src_err_i(serr), .dst_err_i(derr),
      .done_i(done), .nrm_ie_i(nie), .abn_ie_i(aie), .busy_o(busy[0]),
      .nrm_flag_o(nf[0]), .abn_flag_o(af[0]), .src_flag_o(sf[0]),
      .dst_flag_o(df[0]), .irq_o(irq[0]));

   dma_cmpl_status #(.NUM_CH(NCH), .CNT_W(CW), .ALLOW_WIDE_UNIT(1'b1)) i_dma_cmpl_status_wide (
      .clk(clk), .rst_n(rst_n), .start_i(start), .clear_i(clear), .byte_cnt_i(cnt),
      .port_size_i(psz), .unit_size_i(usz), .src_err_i(serr), .dst_err_i(derr),
      .done_i(done), .nrm_ie_i(nie), .abn_ie_i(aie), .busy_o(busy[1]),
      .nrm_flag_o(nf[1]), .abn_flag_o(af[1]), .src_flag_o(sf[1]),
      .dst_flag_o(df[1]), .irq_o(irq[1]));

   function automatic bit good_start(int k, int c);
      int p = int'(psz[c*2 +: 2]);
      int u = int'(usz[c*2 +: 2]);
      if (cnt[c*CW +: CW] == 0) return 1'b0;
      if (p == 3 || u == 3) return 1'b0;
      if (k == 0 && u > p) return 1'b0;
      return 1'b1;
   endfunction

   task automatic model_step();
      for (int k = 0; k < 2; k++) begin
         for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
               mb[k][c] = 0; mn[k][c] = 0; ma[k][c] = 0; ms[k][c] = 0; md[k][c] = 0;
            end else if (start[c]) begin
               mn[k][c] = 0; ms[k][c] = 0; md[k][c] = 0;
               mb[k][c] = good_start(k, c);
               ma[k][c] = !mb[k][c];
            end else if (clear[c]) begin
               mn[k][c] = 0; ma[k][c] = 0; ms[k][c] = 0; md[k][c] = 0;
            end else if (mb[k][c]) begin
               if (serr[c] || derr[c]) begin
                  ma[k][c] = 1;
                  ms[k][c] = ms[k][c] | serr[c];
                  md[k][c] = md[k][c] | derr[c];
                  mb[k][c] = 0;
               end else if (done[c]) begin
                  mn[k][c] = 1;
                  mb[k][c] = 0;
               end
            end
         end
      end
   endtask

   task automatic compare();
      for (int k = 0; k < 2; k++) begin
         for (int c = 0; c < NCH; c++) begin
            logic [5:0] act, exp;
            act = {busy[k][c], nf[k][c], af[k][c], sf[k][c], df[k][c], irq[k][c]};
            exp = {mb[k][c], mn[k][c], ma[k][c], ms[k][c], md[k][c],
                   (mn[k][c] & nie[c]) | (ma[k][c] & aie[c])};
            checks++;
            if (act !== exp) begin
               errors++;
               $display("FAIL %s inst %0d ch %0d {busy,nrm,abn,src,dst,irq} actual %b expected %b",
                        cur, k, c, act, exp);
            end
         end
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
      start = '0; clear = '0; serr = '0; derr = '0; done = '0;
   endtask

   task automatic cfg0(int n, int p, int u);
      cnt[0 +: CW] = CW'(n);
      psz[0 +: 2]  = 2'(p);
      usz[0 +: 2]  = 2'(u);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1 actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      start = '0; clear = '0; serr = '0; derr = '0; done = '0;
      nie = '1; aie = '1;
      cnt = '0; psz = '0; usz = '0;
      for (int c = 0; c < NCH; c++) cnt[c*CW +: CW] = CW'(c + 1);
      tick(); tick();
      @(negedge clk); rst_n = 1'b1;
      cur = "R1"; tick();

      cur = "R2"; cfg0(5, 2, 2); start[0] = 1; tick(); tick();
      cur = "R3"; done[0] = 1; tick();
      cur = "R12"; nie[0] = 0; tick(); nie[0] = 1; tick();
      cur = "R10"; tick(); clear[0] = 1; tick();
      cur = "R4"; start[0] = 1; tick(); serr[0] = 1; tick();
      start[0] = 1; tick(); derr[0] = 1; tick();
      start[0] = 1; tick(); serr[0] = 1; derr[0] = 1; tick();
      cur = "R12"; aie[0] = 0; tick(); aie[0] = 1; tick();
      cur = "R5"; start[0] = 1; tick(); done[0] = 1; serr[0] = 1; tick();
      cur = "R6"; cfg0(0, 2, 2); start[0] = 1; tick();
      cur = "R11"; cfg0(15, 1, 1); start[0] = 1; tick();
      cur = "R10"; clear[0] = 1; tick();
      cur = "R7"; cfg0(3, 3, 0); start[0] = 1; tick();
      cfg0(3, 2, 3); start[0] = 1; tick();
      cur = "R8"; cfg0(4, 0, 2); start[0] = 1; tick(); done[0] = 1; tick();
      cfg0(4, 2, 0); start[0] = 1; tick();
      cur = "R9"; cfg0(4, 1, 1); clear[0] = 1; tick();
      done[0] = 1; serr[0] = 1; derr[0] = 1; tick(); tick();

      cur = "R12";
      for (int i = 0; i < 2000; i++) begin
         for (int c = 0; c < NCH; c++) begin
            start[c] = ($urandom_range(7) == 0);
            clear[c] = ($urandom_range(11) == 0);
            serr[c]  = ($urandom_range(9) == 0);
            derr[c]  = ($urandom_range(9) == 0);
            done[c]  = ($urandom_range(4) == 0);
            nie[c]   = 1'($urandom_range(1));
            aie[c]   = 1'($urandom_range(1));
            cnt[c*CW +: CW] = CW'($urandom_range(3) == 0 ? 0 : $urandom_range(15));
            psz[c*2 +: 2]   = 2'($urandom_range(3));
            usz[c*2 +: 2]   = 2'($urandom_range(3));
         end
         tick();
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule